// File: doc/BRIEF.md
# ULPI Link-Side Byte Interface

This block sits on the link side of an 8-bit single-data-rate ULPI connection. It runs entirely on the clock that the PHY supplies. It turns three inner-facing ports into the correct sequences on the PHY's control lines and data bus. The first is a transmit byte stream with valid/ready/last. The second is a receive byte stream with a separate status port for RX command bytes. The third is a small request port for writing or reading one PHY register. Ownership of the data bus follows the PHY's direction line. The block inserts the one-cycle turnaround whenever that line changes level.

The bus is presented as separate input, output and output-enable vectors, and the pad ring merges them into one bidirectional bus. A transmit packet is offered as a stream. Its first byte carries the PID in its low nibble, and the block replaces that byte with a transmit command byte. Any later bytes go out unchanged. A register write or read is requested with a single-cycle grant handshake. Its result comes back as a done or fail pulse, and for a read also as the returned byte.

Top module: `ulpi_link`

## Requirements
- R1: When the direction line has been low for this cycle and the previous one, the link drives the bus (`ulpiDataOe`=1). When it is idle it drives all zeros with `ulpiStp` low.
- R2: `ulpiDataOe` is 0 in every cycle where `ulpiDir` is high, and in the single turnaround cycle right after `ulpiDir` falls.
- R3: A transmit begins when the link owns the bus and `txValid` is high (`txReady`=1 in that cycle). The first byte driven is the command byte: bits 7:6 = 2'b01, bits 5:4 = 0, bits 3:0 = PID taken from bits 3:0 of the first stream byte. Each byte is held on the bus until a cycle with `ulpiNxt` high, and the next stream byte then appears.
- R4: In the cycle after the last byte is accepted, `ulpiStp` is high for exactly one cycle with the bus at zero. The corresponding done pulse (`txDone` or `regDone`) follows one cycle later.
- R5: A cycle with `ulpiDir` high in both this and the previous cycle and `ulpiNxt` high is a data byte. It appears on `rxData` with `rxValid` one cycle later.
- R6: A cycle with `ulpiDir` high in both this and the previous cycle and `ulpiNxt` low is a status byte. Outside a register read, it appears on `rxCmd` with `rxCmdValid` one cycle later and never raises `rxValid`.
- R7: The bus byte in the turnaround cycle where `ulpiDir` rises is ignored: neither `rxValid` nor `rxCmdValid` follows it.
- R8: A register write is granted (`regGrant`=1) only when the link is idle, owns the bus and no transmit is offered. It drives 2'b10 in bits 7:6 with the 6-bit address below, then the write data after `ulpiNxt`, then a stop as in R4, then `regDone`.
- R9: A register read drives 2'b11 with the address. After `ulpiNxt` it drives zeros until `ulpiDir` rises. It takes the first byte after the turnaround that has `ulpiNxt` low as `regRdata`, pulses `regDone` one cycle later, and raises no `rxCmdValid` for that byte.
- R10: If `ulpiDir` rises while a transmit packet is in progress, the link releases the bus at once. It pulses `txAbort` one cycle later without any stop, and returns to idle.
- R11: A register access fails with a one-cycle `regFail` in two cases: `ulpiDir` rises during its command or write-data byte, or the first byte after the read turnaround has `ulpiNxt` high.
- R12: An offered transmit takes priority over a register request. No transmit or register access starts in a turnaround cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PHY-supplied 60 MHz clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| ulpiDir | input | 1 | PHY direction: high when the PHY owns the bus |
| ulpiNxt | input | 1 | PHY next: byte accepted (link sending) or byte valid (PHY sending) |
| ulpiDataIn | input | 8 | Bus value seen from the pad |
| ulpiDataOut | output | 8 | Bus value driven by the link |
| ulpiDataOe | output | 1 | Output enable for the bus pads |
| ulpiStp | output | 1 | Stop: ends a link-driven sequence |
| txValid | input | 1 | Transmit stream byte offered |
| txData | input | 8 | Transmit stream byte (first byte: PID in bits 3:0) |
| txLast | input | 1 | Offered byte is the last of the packet |
| txReady | output | 1 | Offered byte taken at this edge |
| txDone | output | 1 | Packet completed with stop |
| txAbort | output | 1 | Packet aborted by the PHY taking the bus |
| rxValid | output | 1 | Received data byte valid |
| rxData | output | 8 | Received data byte |
| rxCmdValid | output | 1 | New status byte on rxCmd |
| rxCmd | output | 8 | Last status byte from the PHY |
| regReq | input | 1 | Register access request |
| regWrite | input | 1 | 1 = write, 0 = read |
| regAddr | input | 6 | PHY register address |
| regWdata | input | 8 | Write data |
| regGrant | output | 1 | Request accepted at this edge |
| regDone | output | 1 | Register access finished |
| regFail | output | 1 | Register access failed |
| regRdata | output | 8 | Byte returned by a read |

## Verification
The bench builds the block with its default 8-bit bus width. At that width the address field is 6 bits and the PID field 4 bits, so random addresses, PIDs and payload bytes cover every field position. Packets from zero to five payload bytes meet random acceptance delays of zero to two cycles, which brings byte holding, stop timing and stream refills within reach. Directed cases add the PHY seizing the bus mid-packet and mid-command, a read whose return byte carries data-valid, and turnaround cycles carrying bytes that must be ignored.

// File: rtl/ulpi_link_pkg.sv
package ulpi_link_pkg;

  // command prefixes in bits 7:6 of the first byte the link sends
  localparam logic [1:0] CMD_TX    = 2'b01;
  localparam logic [1:0] CMD_REGWR = 2'b10;
  localparam logic [1:0] CMD_REGRD = 2'b11;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TX,
    ST_REGCMD,
    ST_REGWR,
    ST_RDWAIT,
    ST_STOP
  } linkState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCmd;  // transmit command byte from first stream byte
    logic loadTx;   // next stream byte
    logic loadReg;  // register command byte, capture write data
    logic loadWr;   // captured write data
    logic clear;    // drive idle zeros
    logic capRead;  // current bus byte is register read data
  } dpCtl_t;

endpackage

// File: rtl/ulpi_link_dp.sv
module ulpi_link_dp
  import ulpi_link_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dir,
  input  logic              nxt,
  input  logic [DATA_W-1:0] dataIn,
  input  dpCtl_t            ctl,
  input  logic [DATA_W-1:0] txData,
  input  logic              regWrite,
  input  logic [DATA_W-3:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic              dirQ,
  output logic              rxValid,
  output logic [DATA_W-1:0] rxData,
  output logic              rxCmdValid,
  output logic [DATA_W-1:0] rxCmd,
  output logic [DATA_W-1:0] regRdata
);

  localparam int PID_W = 4;
  localparam int PAD_W = DATA_W - 2 - PID_W;

  logic [DATA_W-1:0] outQ;
  logic [DATA_W-1:0] wdataQ;
  logic              phySends;

  assign phySends = dir && dirQ;
  assign dataOut  = outQ;
  assign dataOe   = !dir && !dirQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dirQ   <= 1'b0;
      outQ   <= '0;
      wdataQ <= '0;
    end else begin
      dirQ <= dir;
      if (ctl.clear) begin
        outQ <= '0;
      end else if (ctl.loadCmd) begin
        outQ <= {CMD_TX, {PAD_W{1'b0}}, txData[PID_W-1:0]};
      end else if (ctl.loadTx) begin
        outQ <= txData;
      end else if (ctl.loadReg) begin
        outQ   <= {(regWrite ? CMD_REGWR : CMD_REGRD), regAddr};
        wdataQ <= regWdata;
      end else if (ctl.loadWr) begin
        outQ <= wdataQ;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxValid    <= 1'b0;
      rxData     <= '0;
      rxCmdValid <= 1'b0;
      rxCmd      <= '0;
      regRdata   <= '0;
    end else begin
      rxValid    <= phySends && nxt;
      rxCmdValid <= phySends && !nxt && !ctl.capRead;
      if (phySends && nxt) rxData <= dataIn;
      if (phySends && !nxt && !ctl.capRead) rxCmd <= dataIn;
      if (ctl.capRead) regRdata <= dataIn;
    end
  end

  // R6: data and status never reported in the same cycle
  p_rx_excl_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(rxValid && rxCmdValid));

  // R7: the byte of the rising turnaround is never reported
  p_no_turn_sample_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dir) |=> (!rxValid && !rxCmdValid));

endmodule

// File: rtl/ulpi_link_ctrl.sv
module ulpi_link_ctrl
  import ulpi_link_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   dir,
  input  logic   dirQ,
  input  logic   nxt,
  input  logic   txValid,
  input  logic   txLast,
  input  logic   regReq,
  input  logic   regWrite,
  output logic   txReady,
  output logic   regGrant,
  output logic   stp,
  output logic   txDone,
  output logic   txAbort,
  output logic   regDone,
  output logic   regFail,
  output dpCtl_t ctl
);

  linkState_t state, stateN;
  logic lastQ, lastN, isTxQ, isTxN, isWrQ, isWrN;
  logic txDoneN, txAbortN, regDoneN, regFailN;
  logic ownBus;

  assign ownBus = !dir && !dirQ;
  assign stp    = (state == ST_STOP);

  always_comb begin
    stateN   = state;
    lastN    = lastQ;
    isTxN    = isTxQ;
    isWrN    = isWrQ;
    ctl      = '0;
    txReady  = 1'b0;
    regGrant = 1'b0;
    txDoneN  = 1'b0;
    txAbortN = 1'b0;
    regDoneN = 1'b0;
    regFailN = 1'b0;
    case (state)
      ST_IDLE: begin
        if (ownBus && txValid) begin
          txReady     = 1'b1;
          ctl.loadCmd = 1'b1;
          lastN       = txLast;
          isTxN       = 1'b1;
          stateN      = ST_TX;
        end else if (ownBus && regReq) begin
          regGrant    = 1'b1;
          ctl.loadReg = 1'b1;
          isWrN       = regWrite;
          isTxN       = 1'b0;
          stateN      = ST_REGCMD;
        end
      end
      ST_TX: begin
        if (dir) begin
          txAbortN  = 1'b1;
          ctl.clear = 1'b1;
          stateN    = ST_IDLE;
        end else if (nxt) begin
          if (!lastQ && txValid) begin
            txReady    = 1'b1;
            ctl.loadTx = 1'b1;
            lastN      = txLast;
          end else begin
            ctl.clear = 1'b1;   // last byte taken (or stream ran dry)
            stateN    = ST_STOP;
          end
        end
      end
      ST_REGCMD, ST_REGWR: begin
        if (dir) begin
          regFailN  = 1'b1;
          ctl.clear = 1'b1;
          stateN    = ST_IDLE;
        end else if (nxt) begin
          if (state == ST_REGCMD && isWrQ) begin
            ctl.loadWr = 1'b1;
            stateN     = ST_REGWR;
          end else begin
            ctl.clear = 1'b1;
            stateN    = (state == ST_REGWR) ? ST_STOP : ST_RDWAIT;
          end
        end
      end
      ST_RDWAIT: begin
        if (dir && dirQ) begin
          if (nxt) begin
            regFailN = 1'b1;
          end else begin
            ctl.capRead = 1'b1;
            regDoneN    = 1'b1;
          end
          stateN = ST_IDLE;
        end
      end
      ST_STOP: begin
        txDoneN  = isTxQ;
        regDoneN = !isTxQ;
        stateN   = ST_IDLE;
      end
      default: stateN = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      lastQ   <= 1'b0;
      isTxQ   <= 1'b0;
      isWrQ   <= 1'b0;
      txDone  <= 1'b0;
      txAbort <= 1'b0;
      regDone <= 1'b0;
      regFail <= 1'b0;
    end else begin
      state   <= stateN;
      lastQ   <= lastN;
      isTxQ   <= isTxN;
      isWrQ   <= isWrN;
      txDone  <= txDoneN;
      txAbort <= txAbortN;
      regDone <= regDoneN;
      regFail <= regFailN;
    end
  end

  // R4: stop lasts one cycle and only follows an accepting cycle
  p_stp_single_r4: assert property (@(posedge clk) disable iff (!rstN)
    stp |=> !stp);
  p_stp_follows_nxt_r4: assert property (@(posedge clk) disable iff (!rstN)
    stp |-> $past(nxt));

  // R10: an aborted packet ends without stop
  p_abort_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    txAbort |-> !stp);

  // R11: a register access ends in exactly one outcome
  p_reg_outcome_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(regDone && regFail));

  // R12: no start while a turnaround is in progress
  p_no_start_turn_r12: assert property (@(posedge clk) disable iff (!rstN)
    (dir != dirQ) |-> (!txReady || state != ST_IDLE) && !regGrant);

endmodule

// File: rtl/ulpi_link.sv
module ulpi_link
  import ulpi_link_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ulpiDir,
  input  logic              ulpiNxt,
  input  logic [DATA_W-1:0] ulpiDataIn,
  output logic [DATA_W-1:0] ulpiDataOut,
  output logic              ulpiDataOe,
  output logic              ulpiStp,
  input  logic              txValid,
  input  logic [DATA_W-1:0] txData,
  input  logic              txLast,
  output logic              txReady,
  output logic              txDone,
  output logic              txAbort,
  output logic              rxValid,
  output logic [DATA_W-1:0] rxData,
  output logic              rxCmdValid,
  output logic [DATA_W-1:0] rxCmd,
  input  logic              regReq,
  input  logic              regWrite,
  input  logic [DATA_W-3:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic              regGrant,
  output logic              regDone,
  output logic              regFail,
  output logic [DATA_W-1:0] regRdata
);

  dpCtl_t ctl;
  logic   dirQ;

  ulpi_link_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .dir      (ulpiDir),
    .dirQ     (dirQ),
    .nxt      (ulpiNxt),
    .txValid  (txValid),
    .txLast   (txLast),
    .regReq   (regReq),
    .regWrite (regWrite),
    .txReady  (txReady),
    .regGrant (regGrant),
    .stp      (ulpiStp),
    .txDone   (txDone),
    .txAbort  (txAbort),
    .regDone  (regDone),
    .regFail  (regFail),
    .ctl      (ctl)
  );

  ulpi_link_dp #(.DATA_W(DATA_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .dir        (ulpiDir),
    .nxt        (ulpiNxt),
    .dataIn     (ulpiDataIn),
    .ctl        (ctl),
    .txData     (txData),
    .regWrite   (regWrite),
    .regAddr    (regAddr),
    .regWdata   (regWdata),
    .dataOut    (ulpiDataOut),
    .dataOe     (ulpiDataOe),
    .dirQ       (dirQ),
    .rxValid    (rxValid),
    .rxData     (rxData),
    .rxCmdValid (rxCmdValid),
    .rxCmd      (rxCmd),
    .regRdata   (regRdata)
  );

  // R2: bus released in the cycle after the PHY hands it back
  p_release_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ulpiDir) |-> !ulpiDataOe);

  // R4: stop cycle drives idle zeros
  p_stp_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    ulpiStp |-> (ulpiDataOut == '0));

  // R4: transmit completion and abort are exclusive
  p_tx_outcome_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(txDone && txAbort));

endmodule

// File: tb/tb_ulpi_link.sv
module tb_ulpi_link;
  localparam int CLK_PERIOD = 16;

  logic clk = 0, rstN = 0;
  logic ulpiDir = 0, ulpiNxt = 0;
  logic [7:0] ulpiDataIn = 0;
  logic [7:0] ulpiDataOut, rxData, rxCmd, regRdata;
  logic ulpiDataOe, ulpiStp, txReady, txDone, txAbort, rxValid, rxCmdValid;
  logic regGrant, regDone, regFail;
  logic txValid = 0, txLast = 0, regReq = 0, regWrite = 0;
  logic [7:0] txData = 0, regWdata = 0;
  logic [5:0] regAddr = 0;
  int tests = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ulpi_link dut (
    .clk(clk), .rstN(rstN), .ulpiDir(ulpiDir), .ulpiNxt(ulpiNxt),
    .ulpiDataIn(ulpiDataIn), .ulpiDataOut(ulpiDataOut), .ulpiDataOe(ulpiDataOe),
    .ulpiStp(ulpiStp), .txValid(txValid), .txData(txData), .txLast(txLast),
    .txReady(txReady), .txDone(txDone), .txAbort(txAbort), .rxValid(rxValid),
    .rxData(rxData), .rxCmdValid(rxCmdValid), .rxCmd(rxCmd), .regReq(regReq),
    .regWrite(regWrite), .regAddr(regAddr), .regWdata(regWdata),
    .regGrant(regGrant), .regDone(regDone), .regFail(regFail), .regRdata(regRdata)
  );

  function automatic logic [7:0] txCmdByte(input logic [3:0] pid);
    return {2'b01, 2'b00, pid};
  endfunction

  function automatic logic [7:0] regCmdByte(input logic wr, input logic [5:0] a);
    return {(wr ? 2'b10 : 2'b11), a};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // hold byte for 0..2 cycles with nxt low, then accept it
  task automatic acceptByte(input logic [7:0] e, input string tag);
    int w = int'($urandom_range(0, 2));
    for (int i = 0; i <= w; i++) begin
      @(negedge clk);
      chk(ulpiDataOut == e && ulpiDataOe, tag, ulpiDataOut, e);
      ulpiNxt = (i == w);
    end
    @(posedge clk); #1 ulpiNxt = 0;
  endtask

  task automatic stopAndDone(input bit isTx, input string tag);
    @(negedge clk);
    chk(ulpiStp && ulpiDataOut == 8'h00, {tag, " R4 stop"}, {ulpiStp, ulpiDataOut}, 9'h100);
    @(negedge clk);
    chk(!ulpiStp, {tag, " R4 stop one cycle"}, ulpiStp, 0);
    if (isTx) chk(txDone, {tag, " R4 txDone"}, txDone, 1);
    else      chk(regDone && !regFail, {tag, " R4 regDone"}, regDone, 1);
  endtask

  task automatic sendPacket(input int n);
    logic [7:0] stream [0:7];
    for (int i = 0; i <= n; i++) stream[i] = 8'($urandom);
    @(negedge clk);
    txValid = 1; txData = stream[0]; txLast = (n == 0);
    #1 chk(txReady, "R3 start taken", txReady, 1);
    @(posedge clk); #1;
    if (n >= 1) begin txData = stream[1]; txLast = (n == 1); end
    else txValid = 0;
    for (int i = 0; i <= n; i++) begin
      acceptByte(i == 0 ? txCmdByte(stream[0][3:0]) : stream[i], "R3 tx byte");
      if (i + 2 <= n) begin txData = stream[i+2]; txLast = (i + 2 == n); end
      else txValid = 0;
    end
    stopAndDone(1, "tx");
  endtask

  task automatic regStart(input logic wr, input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    regReq = 1; regWrite = wr; regAddr = a; regWdata = d;
    #1 chk(regGrant, "R8 grant when idle", regGrant, 1);
    @(posedge clk); #1 regReq = 0; regWdata = 8'($urandom);
  endtask

  task automatic regWriteOp(input logic [5:0] a, input logic [7:0] d);
    regStart(1, a, d);
    acceptByte(regCmdByte(1, a), "R8 write command");
    acceptByte(d, "R8 write data");
    stopAndDone(0, "R8 write");
  endtask

  task automatic regReadOp(input logic [5:0] a, input bit badNxt);
    logic [7:0] rd = 8'($urandom);
    regStart(0, a, 8'h00);
    acceptByte(regCmdByte(0, a), "R9 read command");
    @(negedge clk);
    chk(ulpiDataOut == 0 && ulpiDataOe && !ulpiStp, "R9 idle while waiting", ulpiDataOut, 0);
    ulpiDir = 1; ulpiDataIn = 8'($urandom);
    #1 chk(!ulpiDataOe, "R2 release on dir", ulpiDataOe, 0);
    @(negedge clk);
    ulpiDataIn = rd; ulpiNxt = badNxt;
    @(negedge clk);
    if (badNxt) begin
      chk(regFail && !regDone, "R11 read fail on nxt", regFail, 1);
      chk(rxValid && rxData == rd, "R5 stray data byte", rxData, rd);
    end else begin
      chk(regDone && !regFail && regRdata == rd, "R9 read data", regRdata, rd);
      chk(!rxCmdValid && !rxValid, "R9 no status for read byte", rxCmdValid, 0);
    end
    ulpiDir = 0; ulpiNxt = 0;
    #1 chk(!ulpiDataOe, "R2 turnaround after fall", ulpiDataOe, 0);
    @(negedge clk);
    chk(ulpiDataOe && ulpiDataOut == 0, "R1 idle after read", ulpiDataOut, 0);
  endtask

  task automatic checkRx(input int kind, input logic [7:0] b);
    if (kind == 0)
      chk(!rxValid && !rxCmdValid, "R7 turnaround ignored", {rxValid, rxCmdValid}, 0);
    else if (kind == 1)
      chk(rxValid && !rxCmdValid && rxData == b, "R5 rx data", rxData, b);
    else
      chk(rxCmdValid && !rxValid && rxCmd == b, "R6 rx status", rxCmd, b);
  endtask

  task automatic rxBurst(input int n);
    int kind;
    logic [7:0] b;
    @(negedge clk);
    ulpiDir = 1; ulpiNxt = 1; ulpiDataIn = 8'($urandom);
    kind = 0; b = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      checkRx(kind, b);
      ulpiNxt = 1'($urandom_range(0, 1)); ulpiDataIn = 8'($urandom);
      kind = ulpiNxt ? 1 : 2; b = ulpiDataIn;
    end
    @(negedge clk);
    checkRx(kind, b);
    ulpiDir = 0; ulpiNxt = 0;
    txValid = 1; txData = 8'h00; txLast = 1;
    #1 chk(!txReady, "R12 no start in turnaround", txReady, 0);
    chk(!ulpiDataOe, "R2 turnaround after fall", ulpiDataOe, 0);
    txValid = 0;
    @(negedge clk);
    chk(ulpiDataOe && !rxValid && !rxCmdValid, "R1 own bus after turnaround", ulpiDataOe, 1);
  endtask

  task automatic abortOp();
    logic [7:0] p = 8'($urandom);
    @(negedge clk);
    txValid = 1; txData = p; txLast = 0;
    @(posedge clk); #1 txData = 8'($urandom);
    acceptByte(txCmdByte(p[3:0]), "R3 tx command");
    @(negedge clk);
    ulpiDir = 1;
    #1 chk(!ulpiDataOe, "R10 bus released on dir", ulpiDataOe, 0);
    @(negedge clk);
    chk(txAbort && !ulpiStp && !txDone, "R10 abort reported", txAbort, 1);
    txValid = 0; ulpiDir = 0;
    @(negedge clk);
    chk(!ulpiStp && !txAbort, "R10 no stop after abort", ulpiStp, 0);
    @(negedge clk);
    chk(ulpiDataOe && ulpiDataOut == 0, "R10 idle after abort", ulpiDataOut, 0);
  endtask

  task automatic regCmdFail();
    regStart(1, 6'($urandom), 8'($urandom));
    @(negedge clk);
    ulpiDir = 1;
    @(negedge clk);
    chk(regFail && !regDone, "R11 fail on dir during command", regFail, 1);
    ulpiDir = 0;
    @(negedge clk);
    @(negedge clk);
    chk(ulpiDataOe && ulpiDataOut == 0 && !ulpiStp, "R11 idle after fail", ulpiDataOut, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    @(negedge clk);
    chk(ulpiDataOe && ulpiDataOut == 0 && !ulpiStp, "R1 reset idle", {ulpiDataOe, ulpiDataOut}, 9'h100);
    chk(!txDone && !regDone && !rxValid && !rxCmdValid, "R1 reset pulses low", 0, 0);

    // directed corners
    sendPacket(0);
    sendPacket(3);
    @(negedge clk);
    txValid = 1; regReq = 1; txData = 0; txLast = 1;
    #1 chk(txReady && !regGrant, "R12 transmit first", {txReady, regGrant}, 2'b10);
    txValid = 0; regReq = 0;
    regWriteOp(6'h3f, 8'ha5);
    regReadOp(6'h00, 0);
    regReadOp(6'h15, 1);
    rxBurst(6);
    abortOp();
    regCmdFail();

    // random mix
    for (int k = 0; k < 60; k++) begin
      case ($urandom_range(0, 3))
        0: sendPacket(int'($urandom_range(0, 5)));
        1: regWriteOp(6'($urandom), 8'($urandom));
        2: regReadOp(6'($urandom), 0);
        default: rxBurst(int'($urandom_range(1, 8)));
      endcase
    end

    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule